// File: doc/BRIEF.md
# Processor Operating Mode Controller

This block follows the processor through its operating modes: RESET, RUN, HALT, SLEEP and DEBUG. The core reports three instructions with single-cycle strobes: halt, sleep and debug-return. The controller also watches a set of wake sources: a vector of peripheral interrupt requests, a non-maskable interrupt, a debug interrupt and a reset request. From these it decides the next mode.

Any pending wake source returns the block from HALT or SLEEP to RUN. This happens whether or not the core later takes the interrupt. A debug interrupt is the exception: it goes to DEBUG from RUN, HALT or SLEEP, and the debug-return strobe brings the block back to RUN.

The block drives three outputs. The first is the current mode as a 3-bit code. The second is an enable for the core clock. The third is a request that the oscillators stop, raised only while the block is sleeping. All three outputs come straight from registers and change together on the clock edge where the mode changes.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: An active-low asynchronous reset forces mode RESET with the clock enable low and the oscillator-stop request low. The block stays in RESET while boot_done_i is low. It moves to RUN at the first clock edge that samples boot_done_i high.
- R2: The mode output uses the codes RESET=0, RUN=1, HALT=2, SLEEP=3, DEBUG=4. No other value ever appears.
- R3: In RUN, a halt strobe alone moves the block to HALT at the next edge. In HALT the clock enable is low and the oscillator-stop request stays low.
- R4: In RUN, a sleep strobe moves the block to SLEEP at the next edge. In SLEEP the clock enable is low and the oscillator-stop request is high. The request is high in no other mode.
- R5: In HALT or SLEEP, each wake source on its own moves the block to RUN at the next edge: any bit of the peripheral request vector, the NMI, or the reset request. The clock enable rises and the oscillator-stop request falls at that same edge.
- R6: A debug interrupt in RUN, HALT or SLEEP moves the block to DEBUG at the next edge. This takes priority over every other input present in the same cycle.
- R7: DEBUG is left only by a debug-return strobe, which moves the block to RUN at the next edge. Halt strobes, sleep strobes and wake sources have no effect in DEBUG.
- R8: In RUN, the wake sources and a debug-return strobe have no effect. In HALT and SLEEP, the halt, sleep and debug-return strobes have no effect.
- R9: In RUN, a sleep strobe wins over a halt strobe that arrives in the same cycle.
- R10: The core clock enable is high in RUN and DEBUG and low in RESET, HALT and SLEEP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Controller clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| boot_done_i | input | 1 | Boot sequence finished |
| halt_stb_i | input | 1 | Halt instruction strobe |
| sleep_stb_i | input | 1 | Sleep instruction strobe |
| dbg_ret_stb_i | input | 1 | Debug-return instruction strobe |
| periph_irq_i | input | IRQ_W | Peripheral interrupt requests |
| nmi_i | input | 1 | Non-maskable interrupt |
| dbg_irq_i | input | 1 | Debug interrupt |
| reset_req_i | input | 1 | Reset request, used as a wake source |
| mode_o | output | 3 | Current mode code |
| core_clk_en_o | output | 1 | Core clock enable |
| osc_off_req_o | output | 1 | Oscillator-stop request |

## Verification
The hardest cases to reach are the ones where several inputs land in the same cycle. Examples are a debug interrupt arriving together with a wake source while the block sleeps, all three instruction strobes in one RUN cycle, and wake sources or instruction strobes applied in modes that must ignore them. Each scenario first drives the block into the mode it needs with single-cycle strobes. It then applies the colliding inputs in one cycle and reads all three outputs one edge later. Each wake source is tried separately from both HALT and SLEEP, including the top bit of the peripheral vector. An asynchronous reset is also asserted in the middle of SLEEP.

// File: rtl/pmc_pkg.sv
package pmc_pkg;

    typedef enum logic [2:0] {
        MODE_RESET = 3'd0,
        MODE_RUN   = 3'd1,
        MODE_HALT  = 3'd2,
        MODE_SLEEP = 3'd3,
        MODE_DEBUG = 3'd4
    } mode_e;

    typedef struct packed {
        mode_e mode;
        logic  clk_en;
        logic  osc_off;
    } pmc_state_t;

    localparam pmc_state_t PMC_RESET_STATE = '{mode: MODE_RESET, clk_en: 1'b0, osc_off: 1'b0};

    // Clock enable is a pure function of the mode being entered.
    function automatic logic clk_en_for(input mode_e m);
        return (m == MODE_RUN) || (m == MODE_DEBUG);
    endfunction

    // Oscillator-stop request is a pure function of the mode being entered.
    function automatic logic osc_off_for(input mode_e m);
        return (m == MODE_SLEEP);
    endfunction

endpackage

// File: rtl/pmc_wake_merge.sv
module pmc_wake_merge #(
    parameter int IRQ_W = 8
) (
    input  logic [IRQ_W-1:0] periph_irq_i,
    input  logic             nmi_i,
    input  logic             reset_req_i,
    output logic             wake_o
);
    localparam int NSRC = IRQ_W + 2;

    logic [NSRC-1:0] src;

    // Gather every wake source into one flat vector.
    generate
        for (genvar g = 0; g < IRQ_W; g++) begin : g_irq
            assign src[g] = periph_irq_i[g];
        end
    endgenerate
    assign src[IRQ_W]   = nmi_i;
    assign src[IRQ_W+1] = reset_req_i;

    // Any one source raises the wake signal; acceptance by the core plays no part.
    assign wake_o = |src;

endmodule

// File: rtl/pmc_mode_fsm.sv
module pmc_mode_fsm
    import pmc_pkg::*;
(
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       boot_done_i,
    input  logic       halt_stb_i,
    input  logic       sleep_stb_i,
    input  logic       dbg_ret_stb_i,
    input  logic       dbg_irq_i,
    input  logic       wake_i,
    output pmc_state_t state_o
);
    pmc_state_t st_d, st_q;
    mode_e      nxt;

    always_comb begin
        nxt = st_q.mode;
        unique case (st_q.mode)
            MODE_RESET: begin
                if (boot_done_i) nxt = MODE_RUN;
            end
            MODE_RUN: begin
                // Debug interrupt first, then sleep, then halt.
                if (dbg_irq_i)        nxt = MODE_DEBUG;
                else if (sleep_stb_i) nxt = MODE_SLEEP;
                else if (halt_stb_i)  nxt = MODE_HALT;
            end
            MODE_HALT, MODE_SLEEP: begin
                if (dbg_irq_i)   nxt = MODE_DEBUG;
                else if (wake_i) nxt = MODE_RUN;
            end
            MODE_DEBUG: begin
                if (dbg_ret_stb_i) nxt = MODE_RUN;
            end
            default: nxt = MODE_RESET;
        endcase
        st_d.mode    = nxt;
        st_d.clk_en  = clk_en_for(nxt);
        st_d.osc_off = osc_off_for(nxt);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= PMC_RESET_STATE;
        else         st_q <= st_d;
    end

    assign state_o = st_q;

endmodule

// File: rtl/pmc_out_drive.sv
module pmc_out_drive
    import pmc_pkg::*;
(
    input  pmc_state_t state_i,
    output logic [2:0] mode_o,
    output logic       core_clk_en_o,
    output logic       osc_off_req_o
);
    assign mode_o        = state_i.mode;
    assign core_clk_en_o = state_i.clk_en;
    assign osc_off_req_o = state_i.osc_off;
endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
    import pmc_pkg::*;
#(
    parameter int IRQ_W = 8
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             boot_done_i,
    input  logic             halt_stb_i,
    input  logic             sleep_stb_i,
    input  logic             dbg_ret_stb_i,
    input  logic [IRQ_W-1:0] periph_irq_i,
    input  logic             nmi_i,
    input  logic             dbg_irq_i,
    input  logic             reset_req_i,
    output logic [2:0]       mode_o,
    output logic             core_clk_en_o,
    output logic             osc_off_req_o
);
    logic       wake;
    pmc_state_t state;

    pmc_wake_merge #(.IRQ_W(IRQ_W)) wake_i (
        .periph_irq_i (periph_irq_i),
        .nmi_i        (nmi_i),
        .reset_req_i  (reset_req_i),
        .wake_o       (wake)
    );

    pmc_mode_fsm fsm_i (
        .clk_i         (clk_i),
        .rst_ni        (rst_ni),
        .boot_done_i   (boot_done_i),
        .halt_stb_i    (halt_stb_i),
        .sleep_stb_i   (sleep_stb_i),
        .dbg_ret_stb_i (dbg_ret_stb_i),
        .dbg_irq_i     (dbg_irq_i),
        .wake_i        (wake),
        .state_o       (state)
    );

    pmc_out_drive out_i (
        .state_i       (state),
        .mode_o        (mode_o),
        .core_clk_en_o (core_clk_en_o),
        .osc_off_req_o (osc_off_req_o)
    );

endmodule

// File: rtl/pmc_checker.sv
module pmc_checker #(
    parameter int IRQ_W = 8
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic             boot_done_i,
    input logic             halt_stb_i,
    input logic             sleep_stb_i,
    input logic             dbg_ret_stb_i,
    input logic [IRQ_W-1:0] periph_irq_i,
    input logic             nmi_i,
    input logic             dbg_irq_i,
    input logic             reset_req_i,
    input logic [2:0]       mode_o,
    input logic             core_clk_en_o,
    input logic             osc_off_req_o
);
    logic any_wake;
    logic parked;

    assign any_wake = (|periph_irq_i) || nmi_i || reset_req_i;
    assign parked   = (mode_o == 3'd2) || (mode_o == 3'd3);

    assert_boot_hold_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mode_o == 3'd0 && !boot_done_i) |=> (mode_o == 3'd0));

    assert_mode_legal_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mode_o <= 3'd4));

    assert_halt_entry_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mode_o == 3'd1 && halt_stb_i && !sleep_stb_i && !dbg_irq_i) |=> (mode_o == 3'd2));

    assert_osc_off_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        osc_off_req_o == (mode_o == 3'd3));

    assert_wake_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (parked && any_wake && !dbg_irq_i) |=> (mode_o == 3'd1 && core_clk_en_o && !osc_off_req_o));

    assert_debug_entry_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mode_o >= 3'd1 && mode_o <= 3'd3 && dbg_irq_i) |=> (mode_o == 3'd4));

    assert_debug_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mode_o == 3'd4 && !dbg_ret_stb_i) |=> (mode_o == 3'd4));

    assert_run_ignore_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mode_o == 3'd1 && !halt_stb_i && !sleep_stb_i && !dbg_irq_i) |=> (mode_o == 3'd1));

    assert_sleep_wins_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mode_o == 3'd1 && sleep_stb_i && !dbg_irq_i) |=> (mode_o == 3'd3));

    assert_clk_en_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        core_clk_en_o == (mode_o == 3'd1 || mode_o == 3'd4));

endmodule

bind pwr_mode_ctrl pmc_checker #(.IRQ_W(IRQ_W)) chk_i (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .boot_done_i   (boot_done_i),
    .halt_stb_i    (halt_stb_i),
    .sleep_stb_i   (sleep_stb_i),
    .dbg_ret_stb_i (dbg_ret_stb_i),
    .periph_irq_i  (periph_irq_i),
    .nmi_i         (nmi_i),
    .dbg_irq_i     (dbg_irq_i),
    .reset_req_i   (reset_req_i),
    .mode_o        (mode_o),
    .core_clk_en_o (core_clk_en_o),
    .osc_off_req_o (osc_off_req_o)
);

// File: tb/pwr_mode_ctrl_tb_top.sv
module pwr_mode_ctrl_tb_top;
    localparam int IRQ_W = 8;
    localparam logic [2:0] M_RST = 3'd0, M_RUN = 3'd1, M_HLT = 3'd2, M_SLP = 3'd3, M_DBG = 3'd4;

    logic             clk_i = 1'b0;
    logic             rst_ni = 1'b0;
    logic             boot_done_i = 1'b0;
    logic             halt_stb_i = 1'b0;
    logic             sleep_stb_i = 1'b0;
    logic             dbg_ret_stb_i = 1'b0;
    logic [IRQ_W-1:0] periph_irq_i = '0;
    logic             nmi_i = 1'b0;
    logic             dbg_irq_i = 1'b0;
    logic             reset_req_i = 1'b0;
    logic [2:0]       mode_o;
    logic             core_clk_en_o;
    logic             osc_off_req_o;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    always #2 clk_i = ~clk_i;

    pwr_mode_ctrl #(.IRQ_W(IRQ_W)) dut_i (
        .clk_i(clk_i), .rst_ni(rst_ni), .boot_done_i(boot_done_i),
        .halt_stb_i(halt_stb_i), .sleep_stb_i(sleep_stb_i), .dbg_ret_stb_i(dbg_ret_stb_i),
        .periph_irq_i(periph_irq_i), .nmi_i(nmi_i), .dbg_irq_i(dbg_irq_i),
        .reset_req_i(reset_req_i), .mode_o(mode_o), .core_clk_en_o(core_clk_en_o),
        .osc_off_req_o(osc_off_req_o)
    );

    always @(posedge clk_i) begin
        cyc++;
        if (cyc > 100000) begin
            fails++;
            checks++;
            $display("FAIL watchdog: run did not finish, cycle %0d expected below 100000", cyc);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    task automatic step();
        @(posedge clk_i);
        @(negedge clk_i);
    endtask

    task automatic quiet();
        halt_stb_i = 1'b0; sleep_stb_i = 1'b0; dbg_ret_stb_i = 1'b0;
        periph_irq_i = '0; nmi_i = 1'b0; dbg_irq_i = 1'b0; reset_req_i = 1'b0;
    endtask

    function automatic logic exp_ce(input logic [2:0] m);
        return (m == M_RUN) || (m == M_DBG);
    endfunction

    task automatic expect_mode(input logic [2:0] m, input string tag);
        logic eo;
        logic ec;
        eo = (m == M_SLP);
        ec = exp_ce(m);
        checks++;
        if (mode_o !== m || core_clk_en_o !== ec || osc_off_req_o !== eo) begin
            fails++;
            $display("FAIL %s: mode/clk_en/osc_off = %0d/%b/%b expected %0d/%b/%b",
                     tag, mode_o, core_clk_en_o, osc_off_req_o, m, ec, eo);
        end
    endtask

    // Apply one cycle of stimulus already set up by the caller, then clear it.
    task automatic pulse();
        step();
        quiet();
    endtask

    task automatic do_reset_boot();
        @(negedge clk_i);
        quiet();
        boot_done_i = 1'b0;
        rst_ni = 1'b0;
        #1;
        expect_mode(M_RST, "R1 async reset");
        @(negedge clk_i);
        rst_ni = 1'b1;
        step();
        expect_mode(M_RST, "R1 hold without boot_done");
        step();
        expect_mode(M_RST, "R10 clock off in RESET");
        boot_done_i = 1'b1;
        step();
        expect_mode(M_RUN, "R1 RUN after boot_done");
        boot_done_i = 1'b0;
        step();
        expect_mode(M_RUN, "R2 RUN code is 1");
    endtask

    task automatic t_halt_wake();
        for (int s = 0; s < 4; s++) begin
            halt_stb_i = 1'b1;
            pulse();
            expect_mode(M_HLT, "R3 enter HALT");
            step();
            expect_mode(M_HLT, "R3 HALT holds");
            case (s)
                0: periph_irq_i[0] = 1'b1;
                1: nmi_i = 1'b1;
                2: reset_req_i = 1'b1;
                default: periph_irq_i[3] = 1'b1;
            endcase
            pulse();
            expect_mode(M_RUN, "R5 wake from HALT");
        end
    endtask

    task automatic t_sleep_wake();
        for (int s = 0; s < 3; s++) begin
            sleep_stb_i = 1'b1;
            pulse();
            expect_mode(M_SLP, "R4 enter SLEEP");
            case (s)
                0: periph_irq_i[IRQ_W-1] = 1'b1;
                1: nmi_i = 1'b1;
                default: reset_req_i = 1'b1;
            endcase
            pulse();
            expect_mode(M_RUN, "R5 wake from SLEEP");
        end
    endtask

    task automatic t_debug();
        dbg_irq_i = 1'b1;
        pulse();
        expect_mode(M_DBG, "R6 DEBUG from RUN");
        halt_stb_i = 1'b1;
        pulse();
        expect_mode(M_DBG, "R7 halt ignored in DEBUG");
        sleep_stb_i = 1'b1; nmi_i = 1'b1; periph_irq_i = '1;
        pulse();
        expect_mode(M_DBG, "R7 sleep and wakes ignored in DEBUG");
        dbg_ret_stb_i = 1'b1;
        pulse();
        expect_mode(M_RUN, "R7 return to RUN");

        halt_stb_i = 1'b1;
        pulse();
        dbg_irq_i = 1'b1;
        pulse();
        expect_mode(M_DBG, "R6 DEBUG from HALT");
        dbg_ret_stb_i = 1'b1;
        pulse();
        expect_mode(M_RUN, "R7 return after HALT");

        sleep_stb_i = 1'b1;
        pulse();
        dbg_irq_i = 1'b1; nmi_i = 1'b1; periph_irq_i[2] = 1'b1;
        pulse();
        expect_mode(M_DBG, "R6 debug beats wake in SLEEP");
        dbg_ret_stb_i = 1'b1;
        pulse();
        expect_mode(M_RUN, "R7 return after SLEEP");
    endtask

    task automatic t_ignore_and_priority();
        periph_irq_i = '1; nmi_i = 1'b1; reset_req_i = 1'b1; dbg_ret_stb_i = 1'b1;
        pulse();
        expect_mode(M_RUN, "R8 wakes ignored in RUN");
        halt_stb_i = 1'b1;
        pulse();
        sleep_stb_i = 1'b1; dbg_ret_stb_i = 1'b1; halt_stb_i = 1'b1;
        pulse();
        expect_mode(M_HLT, "R8 strobes ignored in HALT");
        nmi_i = 1'b1;
        pulse();
        sleep_stb_i = 1'b1;
        pulse();
        halt_stb_i = 1'b1; dbg_ret_stb_i = 1'b1; sleep_stb_i = 1'b1;
        pulse();
        expect_mode(M_SLP, "R8 strobes ignored in SLEEP");
        reset_req_i = 1'b1;
        pulse();
        halt_stb_i = 1'b1; sleep_stb_i = 1'b1;
        pulse();
        expect_mode(M_SLP, "R9 sleep beats halt");
        nmi_i = 1'b1;
        pulse();
        halt_stb_i = 1'b1; sleep_stb_i = 1'b1; dbg_irq_i = 1'b1;
        pulse();
        expect_mode(M_DBG, "R6 debug beats strobes in RUN");
        dbg_ret_stb_i = 1'b1;
        pulse();
        expect_mode(M_RUN, "R7 back to RUN");
    endtask

    task automatic t_reset_in_sleep();
        sleep_stb_i = 1'b1;
        pulse();
        expect_mode(M_SLP, "R4 SLEEP before reset");
        do_reset_boot();
    endtask

    initial begin
        quiet();
        do_reset_boot();
        t_halt_wake();
        t_sleep_wake();
        t_debug();
        t_ignore_and_priority();
        t_reset_in_sleep();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule